// File: doc/BRIEF.md
# Oversampling Averaging Filter

This block takes the conversion stream of a multichannel sampling front end and turns each burst of oversampled conversions into one mean value per channel. Each beat carries a 16-bit two's-complement sample and a channel index. Within a burst the channels arrive interleaved: one full set of channel 0 to channel 7 for every oversampling step.

A sequencer pulses a burst-start input. On that pulse the block clears its per-channel sums and captures the averaging ratio. It then adds each accepted sample into the sum of its channel. The burst ends when the last channel's sample of the final step arrives. On that clock edge all eight result registers are loaded with the sum divided by the ratio, and a one-cycle ready pulse is raised. The result registers hold their values until the next burst completes.

Top module: `ovs_avg_filter`

## Requirements
- R1: While reset is high, and on the first cycle after it, all result registers read zero and the ready output is low.
- R2: The ratio select code k is a 3-bit field. Codes 0 to 6 select N = 2^k samples per channel. Code 7 is treated as code 6, so N = 64.
- R3: With N = 1, each result equals the single sample that channel received in the burst, unchanged.
- R4: Each result equals the burst sum of its channel shifted arithmetically right by log2(N), which rounds toward negative infinity. For example, samples -1 and 0 give -1, and samples -3 and 0 give -2.
- R5: Sums of 64 full-scale samples do not overflow. Sixty-four samples of 32767 give 32767, and sixty-four samples of -32768 give -32768.
- R6: Channels are averaged independently. The result for channel c (bits 16c+15 down to 16c of the result bus) depends only on samples tagged with index c.
- R7: The burst completes on the clock edge that accepts the N-th sample for channel 7. All eight results change on that edge, and the ready output is high for exactly the following cycle only.
- R8: Burst start clears every sum and captures the ratio. A change of the ratio select during a burst has no effect, and a new burst start abandons any burst in progress.
- R9: The following beats are discarded: a beat with a channel index of 8 or more, a beat outside a burst, and a beat in the same cycle as burst start.
- R10: Between completions the result registers keep their values, whatever samples arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_data_i | input | 16 | Sample, two's complement |
| smp_ch_i | input | 4 | Channel index of the sample |
| smp_valid_i | input | 1 | Sample beat valid |
| ratio_sel_i | input | 3 | Averaging ratio code k, N = 2^k |
| burst_start_i | input | 1 | One-cycle pulse that opens a burst |
| result_o | output | 128 | Eight 16-bit results, channel c in bits 16c+15:16c |
| results_ready_o | output | 1 | One-cycle pulse after results are loaded |

## Verification
The bench sweeps every ratio code, including the aliased code 7, with pseudo-random interleaved data and compares each result against a floor division computed in the bench. A design that rounded toward zero fails the explicit negative-odd cases, and one with a narrow sum wraps on the full-scale bursts. Junk beats with a channel index of 8 or more, beats outside a burst, a sample given together with burst start, a ratio change mid-burst and an abandoned partial burst are all mixed in. Mishandling any of these corrupts a sum, ends the burst at the wrong step, or disturbs results that must hold.

// File: rtl/ovs_avg_pkg.sv
package ovs_avg_pkg;
    localparam int SAMPLE_W    = 16;
    localparam int NUM_CH      = 8;
    localparam int CH_IDX_W    = 4;
    localparam int MAX_LOG2    = 6;
    localparam int RATIO_SEL_W = 3;
    localparam int ACC_W       = SAMPLE_W + MAX_LOG2;
    localparam int STEP_W      = (MAX_LOG2 > 0) ? MAX_LOG2 : 1;
    localparam int SHIFT_W     = $clog2(MAX_LOG2 + 1);

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [ACC_W-1:0]    acc_t;

    typedef struct packed {
        logic                valid;
        logic [CH_IDX_W-1:0] ch;
        sample_t             data;
    } smp_beat_t;

    typedef enum logic {ST_IDLE, ST_BURST} burst_st_e;

    localparam acc_t ACC_SMAX = acc_t'((1 <<< (SAMPLE_W - 1)) - 1);
    localparam acc_t ACC_SMIN = acc_t'(-(1 <<< (SAMPLE_W - 1)));

    function automatic logic [SHIFT_W-1:0] ratio_shift(input logic [RATIO_SEL_W-1:0] sel);
        if (int'(sel) > MAX_LOG2)
            return SHIFT_W'(MAX_LOG2);
        return SHIFT_W'(sel);
    endfunction

    function automatic sample_t mean_sat(input acc_t acc, input logic [SHIFT_W-1:0] sh);
        acc_t q;
        q = acc >>> sh;
        if (q > ACC_SMAX)
            q = ACC_SMAX;
        else if (q < ACC_SMIN)
            q = ACC_SMIN;
        return sample_t'(q[SAMPLE_W-1:0]);
    endfunction
endpackage

// File: rtl/ovs_burst_ctrl.sv
module ovs_burst_ctrl
    import ovs_avg_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   burst_start,
    input  logic [RATIO_SEL_W-1:0] ratio_sel,
    input  smp_beat_t              beat,
    output logic                   accept,
    output logic                   clear,
    output logic                   done,
    output logic [SHIFT_W-1:0]     shift
);
    burst_st_e          st_q;
    logic [SHIFT_W-1:0] shift_q;
    logic [STEP_W-1:0]  step_q;
    logic [STEP_W-1:0]  step_lim;
    logic               last_ch;

    assign step_lim = STEP_W'((1 << shift_q) - 1);
    assign last_ch  = (beat.ch == CH_IDX_W'(NUM_CH - 1));
    assign accept   = (st_q == ST_BURST) && !burst_start && beat.valid
                      && (int'(beat.ch) < NUM_CH);
    assign done     = accept && last_ch && (step_q == step_lim);
    assign clear    = burst_start;
    assign shift    = shift_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            shift_q <= '0;
            step_q  <= '0;
        end else if (burst_start) begin
            st_q    <= ST_BURST;
            shift_q <= ratio_shift(ratio_sel);
            step_q  <= '0;
        end else if (done) begin
            st_q    <= ST_IDLE;
            step_q  <= '0;
        end else if (accept && last_ch) begin
            step_q  <= step_q + 1'b1;
        end
    end
endmodule

// File: rtl/ovs_acc_bank.sv
module ovs_acc_bank
    import ovs_avg_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clear,
    input  logic                        accept,
    input  smp_beat_t                   beat,
    output logic [NUM_CH-1:0][ACC_W-1:0] acc_next
);
    acc_t smp_ext;
    assign smp_ext = acc_t'(beat.data);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        acc_t acc_q;
        acc_t nxt;
        logic hit;

        assign hit = accept && (beat.ch == CH_IDX_W'(c));

        always_comb begin
            if (clear)
                nxt = '0;
            else if (hit)
                nxt = acc_q + smp_ext;
            else
                nxt = acc_q;
        end

        assign acc_next[c] = nxt;

        always_ff @(posedge clk) begin
            if (rst)
                acc_q <= '0;
            else
                acc_q <= nxt;
        end
    end
endmodule

// File: rtl/ovs_result_regs.sv
module ovs_result_regs
    import ovs_avg_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         done,
    input  logic [SHIFT_W-1:0]           shift,
    input  logic [NUM_CH-1:0][ACC_W-1:0] acc_next,
    output logic [NUM_CH*SAMPLE_W-1:0]   result,
    output logic                         ready
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_res
        sample_t res_q;

        always_ff @(posedge clk) begin
            if (rst)
                res_q <= '0;
            else if (done)
                res_q <= mean_sat(acc_t'(acc_next[c]), shift);
        end

        assign result[c*SAMPLE_W +: SAMPLE_W] = res_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ready <= 1'b0;
        else
            ready <= done;
    end
endmodule

// File: rtl/ovs_avg_filter.sv
module ovs_avg_filter
    import ovs_avg_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [SAMPLE_W-1:0]        smp_data_i,
    input  logic [CH_IDX_W-1:0]        smp_ch_i,
    input  logic                       smp_valid_i,
    input  logic [RATIO_SEL_W-1:0]     ratio_sel_i,
    input  logic                       burst_start_i,
    output logic [NUM_CH*SAMPLE_W-1:0] result_o,
    output logic                       results_ready_o
);
    smp_beat_t                   beat;
    logic                        accept;
    logic                        clear;
    logic                        done;
    logic [SHIFT_W-1:0]          shift;
    logic [NUM_CH-1:0][ACC_W-1:0] acc_next;

    assign beat.valid = smp_valid_i;
    assign beat.ch    = smp_ch_i;
    assign beat.data  = sample_t'(smp_data_i);

    ovs_burst_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .burst_start (burst_start_i),
        .ratio_sel   (ratio_sel_i),
        .beat        (beat),
        .accept      (accept),
        .clear       (clear),
        .done        (done),
        .shift       (shift)
    );

    ovs_acc_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .accept   (accept),
        .beat     (beat),
        .acc_next (acc_next)
    );

    ovs_result_regs u_res (
        .clk      (clk),
        .rst      (rst),
        .done     (done),
        .shift    (shift),
        .acc_next (acc_next),
        .result   (result_o),
        .ready    (results_ready_o)
    );
endmodule

// File: rtl/ovs_avg_filter_chk.sv
module ovs_avg_filter_chk
    import ovs_avg_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic [CH_IDX_W-1:0]        smp_ch_i,
    input logic                       smp_valid_i,
    input logic                       burst_start_i,
    input logic [NUM_CH*SAMPLE_W-1:0] result_o,
    input logic                       results_ready_o
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (result_o == '0 && !results_ready_o));

    assert_ready_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        results_ready_o |=> !results_ready_o);

    assert_ready_after_last_ch_R7: assert property (@(posedge clk) disable iff (rst)
        results_ready_o |-> $past(smp_valid_i && !burst_start_i
                                  && smp_ch_i == CH_IDX_W'(NUM_CH - 1)));

    assert_start_no_ready_R9: assert property (@(posedge clk) disable iff (rst)
        burst_start_i |=> !results_ready_o);

    assert_results_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !results_ready_o |-> $stable(result_o));
endmodule

bind ovs_avg_filter ovs_avg_filter_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .smp_ch_i        (smp_ch_i),
    .smp_valid_i     (smp_valid_i),
    .burst_start_i   (burst_start_i),
    .result_o        (result_o),
    .results_ready_o (results_ready_o)
);

// File: tb/ovs_avg_filter_tb.sv
`timescale 1ns/1ps
module ovs_avg_filter_tb;
    import ovs_avg_pkg::*;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic [SAMPLE_W-1:0]        smp_data_i = '0;
    logic [CH_IDX_W-1:0]        smp_ch_i = '0;
    logic                       smp_valid_i = 1'b0;
    logic [RATIO_SEL_W-1:0]     ratio_sel_i = '0;
    logic                       burst_start_i = 1'b0;
    logic [NUM_CH*SAMPLE_W-1:0] result_o;
    logic                       results_ready_o;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    int          sums [NUM_CH];
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #2.5 clk = ~clk;

    ovs_avg_filter u_dut (
        .clk             (clk),
        .rst             (rst),
        .smp_data_i      (smp_data_i),
        .smp_ch_i        (smp_ch_i),
        .smp_valid_i     (smp_valid_i),
        .ratio_sel_i     (ratio_sel_i),
        .burst_start_i   (burst_start_i),
        .result_o        (result_o),
        .results_ready_o (results_ready_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int res(input int c);
        return int'($signed(result_o[c*SAMPLE_W +: SAMPLE_W]));
    endfunction

    function automatic logic [SAMPLE_W-1:0] next_rand();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr[SAMPLE_W-1:0];
    endfunction

    task automatic drive_beat(input int ch, input logic [SAMPLE_W-1:0] d);
        smp_valid_i = 1'b1;
        smp_ch_i    = CH_IDX_W'(ch);
        smp_data_i  = d;
        @(negedge clk);
        smp_valid_i = 1'b0;
    endtask

    // A sample given together with burst start must be discarded (R9)
    task automatic start_burst(input int sel);
        burst_start_i = 1'b1;
        ratio_sel_i   = RATIO_SEL_W'(sel);
        smp_valid_i   = 1'b1;
        smp_ch_i      = '0;
        smp_data_i    = 16'h7FFF;
        @(negedge clk);
        burst_start_i = 1'b0;
        smp_valid_i   = 1'b0;
        for (int c = 0; c < NUM_CH; c++) sums[c] = 0;
    endtask

    task automatic run_burst(input int sel, input int k, input int pattern, input bit junk);
        logic [SAMPLE_W-1:0] d;
        int n;
        n = 1 << k;
        start_burst(sel);
        for (int s = 0; s < n; s++) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (junk && c == 3) begin
                    drive_beat(NUM_CH + (s % NUM_CH), 16'h4000);  // R9 junk index
                    @(negedge clk);
                    ratio_sel_i = ~RATIO_SEL_W'(sel);            // R8 mid-burst change
                end
                case (pattern)
                    1:       d = 16'h7FFF;
                    2:       d = 16'h8000;
                    default: d = next_rand();
                endcase
                sums[c] += int'($signed(d));
                if (s == n - 1 && c == NUM_CH - 1)
                    check("R7 no early ready", int'(results_ready_o), 0);
                drive_beat(c, d);
            end
        end
        check("R7 ready on completion", int'(results_ready_o), 1);
        for (int c = 0; c < NUM_CH; c++) begin
            if (pattern != 0)
                check("R5 full-scale mean", res(c), sums[c] >>> k);
            else if (k == 0)
                check("R3 pass-through", res(c), sums[c]);
            else
                check("R4 R6 floor mean per channel", res(c), sums[c] >>> k);
        end
        @(negedge clk);
        check("R7 ready one cycle", int'(results_ready_o), 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int snap [NUM_CH];
        repeat (3) @(negedge clk);
        for (int c = 0; c < NUM_CH; c++) check("R1 reset result", res(c), 0);
        check("R1 reset ready", int'(results_ready_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready after reset", int'(results_ready_o), 0);

        // beats outside any burst are ignored (R9)
        for (int c = 0; c < NUM_CH; c++) drive_beat(c, 16'h1234);
        @(negedge clk);
        check("R9 outside burst ready", int'(results_ready_o), 0);
        check("R9 outside burst result", res(NUM_CH - 1), 0);

        // every ratio code (R2)
        for (int k = 0; k <= MAX_LOG2; k++) run_burst(k, k, 0, k[0]);
        run_burst(7, MAX_LOG2, 0, 1'b0);   // R2 code 7 acts as 64

        run_burst(6, 6, 1, 1'b0);          // R5 positive full scale
        run_burst(6, 6, 2, 1'b0);          // R5 negative full scale

        // R4 explicit rounding toward negative infinity, N = 2
        start_burst(1);
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (c == 0)      drive_beat(c, (s == 0) ? 16'hFFFF : 16'h0000);
                else if (c == 1) drive_beat(c, (s == 0) ? 16'hFFFD : 16'h0000);
                else             drive_beat(c, SAMPLE_W'(s + 1));
            end
        end
        check("R4 -1,0 gives -1", res(0), -1);
        check("R4 -3,0 gives -2", res(1), -2);
        check("R4 1,2 gives 1", res(2), 1);

        // R8 restart abandons partial burst, new ratio captured
        start_burst(2);
        for (int i = 0; i < 5; i++) drive_beat(i % NUM_CH, 16'h7000);
        start_burst(0);
        for (int c = 0; c < NUM_CH; c++) drive_beat(c, SAMPLE_W'(c * 100 - 300));
        check("R8 restart ready", int'(results_ready_o), 1);
        for (int c = 0; c < NUM_CH; c++) check("R8 restart result", res(c), c * 100 - 300);

        // R10 results hold after completion
        for (int c = 0; c < NUM_CH; c++) snap[c] = res(c);
        for (int c = 0; c < NUM_CH; c++) drive_beat(c, 16'h5555);
        drive_beat(12, 16'h2222);
        repeat (3) @(negedge clk);
        check("R10 no ready between bursts", int'(results_ready_o), 0);
        for (int c = 0; c < NUM_CH; c++) check("R10 result held", res(c), snap[c]);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule